// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block sits in a host bridge and decides, for every memory access below 1 MB, whether the access is served by DRAM or forwarded to the PCI bus. Software programs a set of byte-wide attribute registers and one SMRAM control byte through a simple byte-wide configuration write port. The block uses these to route accesses to the shadow regions between 0xC0000 and 0xFFFFF and to the 128 KB SMRAM window at 0xA0000.

Thirteen regions carry their own read and write enables. Region 0 is the 64 KB BIOS area at 0xF0000. Regions 1 to 12 are 16 KB expansion areas that follow one another upward from 0xC0000. The seven attribute bytes hold two 4-bit fields each, except the first byte, which holds a field only in its upper half. The SMRAM window is steered by an "open" bit and a "global enable" bit in the control byte. The access type (read or write) and whether the access comes from system-management mode both take part in the decision.

Each access is presented with a valid strobe. The routing answer appears one clock later.

Top module: `legacy_attr_decoder`

## Requirements
- R1: After reset every attribute byte (offsets 0x59 to 0x5F) reads 0x00 and the SMRAM control byte (offset 0x72) reads 0x02. Every access at or above 0xA0000 is then routed to PCI (resDram = 0).
- R2: A configuration write to offsets 0x59 to 0x5F or 0x72 stores the full byte. The byte is returned on cfgRdData, combinationally, whenever cfgRdAddr selects that offset.
- R3: Writes to any other offset change no register. Reads of any other offset return 0x00.
- R4: Accesses below 0xA0000 always route to DRAM, whatever the access type, the mode or the register contents.
- R5: Region 0 covers 0xF0000 to 0xFFFFF. Region i (1 to 12) covers 0xC0000 + (i-1)*0x4000 over 0x4000 bytes. Region i takes its field from byte 0x59 + (i+1)/2 (integer division). Region 0 and the even regions use bits 7:4 of that byte; the odd regions use bits 3:0.
- R6: Within a 4-bit field, bit 0 enables DRAM for reads and bit 1 enables DRAM for writes. A cleared enable routes that access type to PCI. Field bits 2 and 3 have no effect on routing.
- R7: For an access with accSmm = 0 in 0xA0000 to 0xBFFFF, the route is DRAM exactly when the SMRAM open bit (bit 6 of offset 0x72) is set. Otherwise the route is PCI.
- R8: For an access with accSmm = 1 in the same window, the route is DRAM when the global enable bit (bit 3 of offset 0x72) or the open bit is set. Otherwise the route is PCI.
- R9: resValid and resDram are registered one cycle after accValid. An access presented in the cycle that also carries a register write sees the old contents. An access presented in the following cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration write offset |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdAddr | input | 8 | Configuration read offset |
| cfgRdData | output | 8 | Configuration read data (combinational) |
| accValid | input | 1 | Memory access to decode is present |
| accAddr | input | 20 | Memory access address |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| accSmm | input | 1 | Access issued in system-management mode |
| resValid | output | 1 | Routing result valid |
| resDram | output | 1 | 1 = DRAM, 0 = PCI |

## Verification
Four behaviours are checked by assertions on every cycle:
- the one-cycle relation between accValid and resValid;
- DRAM routing of all low memory;
- zero readback of unmapped offsets;
- readback of a just-written byte.

The region geometry, the nibble selection, the enable-bit meaning, the two SMRAM views and the reset contents depend on programmed state. Only the bench's scenarios show these, by sweeping the first and last address of every region under distinct attribute patterns and every combination of the two SMRAM bits. The same-cycle write and access ordering is likewise shown only by a directed scenario.

// File: rtl/lgd_pkg.sv
package lgd_pkg;
  // number of attribute bytes; regions = 2*bytes-1
  localparam int ATTR_BYTES = 7;
  localparam int REGIONS    = 2 * ATTR_BYTES - 1;
  // bit positions inside the SMRAM control byte
  localparam int SMR_OPEN_BIT = 6;
  localparam int SMR_GEN_BIT  = 3;
  // bit positions inside an attribute field
  localparam int FLD_RD_BIT = 0;
  localparam int FLD_WR_BIT = 1;

  typedef struct packed {
    logic [ATTR_BYTES-1:0] attrWr;
    logic                  smramWr;
  } cfgStrobe_t;
endpackage

// File: rtl/legacy_attr_ctrl.sv
module legacy_attr_ctrl
  import lgd_pkg::*;
#(
  parameter int                CFG_W     = 8,
  parameter logic [CFG_W-1:0]  ATTR_BASE = 8'h59,
  parameter logic [CFG_W-1:0]  SMRAM_OFF = 8'h72
) (
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgAddr,
  output cfgStrobe_t       strobe
);
  for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_dec
    localparam logic [CFG_W-1:0] OFF = CFG_W'(ATTR_BASE + b);
    assign strobe.attrWr[b] = cfgWrEn && (cfgAddr == OFF);
  end
  assign strobe.smramWr = cfgWrEn && (cfgAddr == SMRAM_OFF);
endmodule

// File: rtl/legacy_attr_dp.sv
module legacy_attr_dp
  import lgd_pkg::*;
#(
  parameter int                CFG_W      = 8,
  parameter int                ADDR_W     = 20,
  parameter logic [CFG_W-1:0]  ATTR_BASE  = 8'h59,
  parameter logic [CFG_W-1:0]  SMRAM_OFF  = 8'h72,
  parameter logic [CFG_W-1:0]  SMRAM_RST  = 8'h02,
  parameter int                BIOS_LOG2  = 16,
  parameter int                EXP_LOG2   = 14,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 20'hA0000,
  parameter int                WIN_LOG2   = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic [CFG_W-1:0]  cfgRdAddr,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic              accSmm,
  output logic              resValid,
  output logic              resDram
);
  localparam int AW1    = ADDR_W + 1;
  localparam int RIDX_W = $clog2(REGIONS);
  localparam int EXP_N  = REGIONS - 1;
  localparam logic [AW1-1:0] TOP_A   = AW1'(1) << ADDR_W;
  localparam logic [AW1-1:0] BIOS_LO = TOP_A - (AW1'(1) << BIOS_LOG2);
  localparam logic [AW1-1:0] EXP_LO  = BIOS_LO - AW1'(EXP_N * (1 << EXP_LOG2));
  localparam logic [AW1-1:0] WIN_LO  = {1'b0, WIN_BASE};
  localparam logic [AW1-1:0] WIN_HI  = WIN_LO + (AW1'(1) << WIN_LOG2);

  logic [CFG_W-1:0] attrReg [ATTR_BYTES];
  logic [CFG_W-1:0] smramReg;

  // register file
  for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_attr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                attrReg[b] <= '0;
      else if (strobe.attrWr[b]) attrReg[b] <= cfgWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               smramReg <= SMRAM_RST;
    else if (strobe.smramWr) smramReg <= cfgWrData;
  end

  // read mux
  always_comb begin
    cfgRdData = '0;
    for (int b = 0; b < ATTR_BYTES; b++) begin
      if (cfgRdAddr == CFG_W'(ATTR_BASE + b)) cfgRdData = attrReg[b];
    end
    if (cfgRdAddr == SMRAM_OFF) cfgRdData = smramReg;
  end

  // per-region enable pair: region 0 and even regions use the high nibble
  logic [1:0] fld [REGIONS];
  for (genvar g = 0; g < REGIONS; g++) begin : g_fld
    localparam int BI = (g + 1) / 2;
    if (g % 2 == 0) begin : g_hi
      assign fld[g] = {attrReg[BI][4+FLD_WR_BIT], attrReg[BI][4+FLD_RD_BIT]};
    end else begin : g_lo
      assign fld[g] = {attrReg[BI][FLD_WR_BIT], attrReg[BI][FLD_RD_BIT]};
    end
  end

  // address classification and lookup
  logic [AW1-1:0]    addrX, expOff;
  logic              isLow, inWin, inBios, inExp, winDram, enBit, dramNext;
  logic [RIDX_W-1:0] regSel;
  logic [1:0]        selFld;

  always_comb begin
    addrX  = {1'b0, accAddr};
    isLow  = addrX < WIN_LO;
    inWin  = (addrX >= WIN_LO) && (addrX < WIN_HI);
    inBios = addrX >= BIOS_LO;
    inExp  = (addrX >= EXP_LO) && !inBios;
    expOff = (addrX - EXP_LO) >> EXP_LOG2;
    regSel = inBios ? '0 : RIDX_W'(expOff) + RIDX_W'(1);
    selFld = '0;
    for (int r = 0; r < REGIONS; r++) begin
      if (regSel == RIDX_W'(r)) selFld = fld[r];
    end
    enBit    = accWrite ? selFld[1] : selFld[0];
    winDram  = smramReg[SMR_OPEN_BIT] || (accSmm && smramReg[SMR_GEN_BIT]);
    dramNext = isLow || (inWin && winDram) || ((inBios || inExp) && enBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resDram  <= 1'b0;
    end else begin
      resValid <= accValid;
      resDram  <= accValid && dramNext;
    end
  end
endmodule

// File: rtl/legacy_attr_decoder.sv
module legacy_attr_decoder
  import lgd_pkg::*;
#(
  parameter int                CFG_W     = 8,
  parameter int                ADDR_W    = 20,
  parameter logic [CFG_W-1:0]  ATTR_BASE = 8'h59,
  parameter logic [CFG_W-1:0]  SMRAM_OFF = 8'h72,
  parameter logic [CFG_W-1:0]  SMRAM_RST = 8'h02,
  parameter int                BIOS_LOG2 = 16,
  parameter int                EXP_LOG2  = 14,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 20'hA0000,
  parameter int                WIN_LOG2  = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic [CFG_W-1:0]  cfgRdAddr,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic              accSmm,
  output logic              resValid,
  output logic              resDram
);
  cfgStrobe_t strobe;

  legacy_attr_ctrl #(
    .CFG_W(CFG_W), .ATTR_BASE(ATTR_BASE), .SMRAM_OFF(SMRAM_OFF)
  ) i_ctrl (
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .strobe(strobe)
  );

  legacy_attr_dp #(
    .CFG_W(CFG_W), .ADDR_W(ADDR_W), .ATTR_BASE(ATTR_BASE),
    .SMRAM_OFF(SMRAM_OFF), .SMRAM_RST(SMRAM_RST), .BIOS_LOG2(BIOS_LOG2),
    .EXP_LOG2(EXP_LOG2), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWrData(cfgWrData),
    .cfgRdAddr(cfgRdAddr), .cfgRdData(cfgRdData), .accValid(accValid),
    .accAddr(accAddr), .accWrite(accWrite), .accSmm(accSmm),
    .resValid(resValid), .resDram(resDram)
  );
endmodule

// File: rtl/legacy_attr_checker.sv
module legacy_attr_checker
  import lgd_pkg::*;
#(
  parameter int                CFG_W     = 8,
  parameter int                ADDR_W    = 20,
  parameter logic [CFG_W-1:0]  ATTR_BASE = 8'h59,
  parameter logic [CFG_W-1:0]  SMRAM_OFF = 8'h72,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 20'hA0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [CFG_W-1:0]  cfgAddr,
  input logic [CFG_W-1:0]  cfgWrData,
  input logic [CFG_W-1:0]  cfgRdAddr,
  input logic [CFG_W-1:0]  cfgRdData,
  input logic              accValid,
  input logic [ADDR_W-1:0] accAddr,
  input logic              resValid,
  input logic              resDram
);
  localparam logic [CFG_W-1:0] ATTR_LAST = CFG_W'(ATTR_BASE + ATTR_BYTES - 1);

  function automatic logic isMapped(input logic [CFG_W-1:0] a);
    return ((a >= ATTR_BASE) && (a <= ATTR_LAST)) || (a == SMRAM_OFF);
  endfunction

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> resValid);
  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !resValid);
  // R4
  low_dram_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accAddr < WIN_BASE) |=> resDram);
  // R3
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isMapped(cfgRdAddr) |-> cfgRdData == '0);
  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && isMapped(cfgAddr) && cfgRdAddr == cfgAddr)
      |=> (!$stable(cfgRdAddr) || cfgRdData == $past(cfgWrData)));
endmodule

bind legacy_attr_decoder legacy_attr_checker #(
  .CFG_W(CFG_W), .ADDR_W(ADDR_W), .ATTR_BASE(ATTR_BASE),
  .SMRAM_OFF(SMRAM_OFF), .WIN_BASE(WIN_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .cfgWrData(cfgWrData), .cfgRdAddr(cfgRdAddr), .cfgRdData(cfgRdData),
  .accValid(accValid), .accAddr(accAddr), .resValid(resValid),
  .resDram(resDram)
);

// File: tb/test_legacy_attr_decoder.sv
`timescale 1ns/1ps
module test_legacy_attr_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = '0, cfgWrData = '0, cfgRdAddr = '0;
  logic [7:0]  cfgRdData;
  logic        accValid = 1'b0, accWrite = 1'b0, accSmm = 1'b0;
  logic [19:0] accAddr = '0;
  logic        resValid, resDram;

  int nChecks = 0, nFail = 0;
  bit done = 0;
  logic [7:0] sh [7];
  logic [7:0] shSmr;

  always #2.5 clk = ~clk;

  legacy_attr_decoder i_legacy_attr_decoder (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdAddr(cfgRdAddr), .cfgRdData(cfgRdData),
    .accValid(accValid), .accAddr(accAddr), .accWrite(accWrite),
    .accSmm(accSmm), .resValid(resValid), .resDram(resDram)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // expected route from the requirements (R4..R8)
  function automatic logic expDram(input logic [19:0] a, input logic wr, input logic smm);
    int r;
    logic [7:0] by;
    logic [3:0] f;
    if (a < 20'hA0000) return 1'b1;
    if (a < 20'hC0000) return shSmr[6] || (smm && shSmr[3]);
    if (a >= 20'hF0000) r = 0;
    else r = 1 + int'((a - 20'hC0000) >> 14);
    by = sh[(r + 1) / 2];
    f = (r % 2 == 0) ? by[7:4] : by[3:0];
    return wr ? f[1] : f[0];
  endfunction

  task automatic cfgWr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a >= 8'h59 && a <= 8'h5F) sh[a - 8'h59] = d;
    if (a == 8'h72) shSmr = d;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cfgRdAddr = a;
    #1 chk(tag, cfgRdData, exp);
  endtask

  task automatic acc(input logic [19:0] a, input logic wr, input logic smm, input string tag);
    logic e;
    e = expDram(a, wr, smm);
    @(negedge clk);
    accValid = 1'b1; accAddr = a; accWrite = wr; accSmm = smm;
    @(negedge clk);
    accValid = 1'b0;
    chk(tag, {7'd0, resDram}, {7'd0, e});
  endtask

  task automatic tReset();
    for (int b = 0; b < 7; b++) rdChk(8'(8'h59 + b), 8'h00, "R1 attr reset");
    rdChk(8'h72, 8'h02, "R1 smram reset");
    acc(20'hC0000, 1'b0, 1'b0, "R1 exp read PCI");
    acc(20'hFFFFF, 1'b1, 1'b0, "R1 bios write PCI");
    acc(20'hA0000, 1'b0, 1'b0, "R1 window PCI");
    acc(20'hBFFFF, 1'b0, 1'b1, "R1 window smm PCI");
    chk("R1 route value", {7'd0, resDram}, 8'd0);
  endtask

  task automatic tLow();
    acc(20'h00000, 1'b0, 1'b0, "R4 low read");
    acc(20'h9FFFF, 1'b1, 1'b1, "R4 low top write smm");
    acc(20'h5A5A5, 1'b1, 1'b0, "R4 low mid");
  endtask

  task automatic tRegions(input logic [7:0] seed);
    for (int b = 0; b < 7; b++) cfgWr(8'(8'h59 + b), 8'(seed * (b + 3) + 8'h21 * b));
    for (int b = 0; b < 7; b++) rdChk(8'(8'h59 + b), sh[b], "R2 attr readback");
    for (int r = 0; r < 13; r++) begin
      logic [19:0] lo, hi;
      lo = (r == 0) ? 20'hF0000 : 20'(20'hC0000 + (r - 1) * 20'h4000);
      hi = (r == 0) ? 20'hFFFFF : 20'(lo + 20'h3FFF);
      acc(lo, 1'b0, 1'b0, "R5 R6 region start read");
      acc(lo, 1'b1, 1'b0, "R5 R6 region start write");
      acc(hi, 1'b0, 1'b1, "R5 R6 region end read");
      acc(hi, 1'b1, 1'b1, "R5 R6 region end write");
    end
  endtask

  task automatic tUpperBits();
    cfgWr(8'h59, 8'hC3);
    cfgWr(8'h5A, 8'h5C);
    acc(20'hF8000, 1'b0, 1'b0, "R6 bits 3:2 ignored read");
    acc(20'hF8000, 1'b1, 1'b0, "R6 bits 3:2 ignored write");
    acc(20'hC1000, 1'b0, 1'b0, "R6 low nibble upper bits ignored");
    acc(20'hC4000, 1'b0, 1'b0, "R6 region2 high nibble read");
  endtask

  task automatic tUnmapped();
    logic [7:0] addrs [5] = '{8'h58, 8'h60, 8'h71, 8'h73, 8'h00};
    cfgWr(8'h59, 8'h30);
    for (int k = 0; k < 5; k++) cfgWr(addrs[k], 8'hFF);
    for (int k = 0; k < 5; k++) rdChk(addrs[k], 8'h00, "R3 unmapped reads zero");
    rdChk(8'h59, 8'h30, "R3 neighbour unchanged");
    rdChk(8'h72, shSmr, "R3 smram unchanged");
    acc(20'hF0000, 1'b0, 1'b0, "R3 route unchanged");
  endtask

  task automatic tSmram();
    logic [7:0] vals [4] = '{8'h02, 8'h42, 8'h0A, 8'h4A};
    for (int k = 0; k < 4; k++) begin
      cfgWr(8'h72, vals[k]);
      rdChk(8'h72, vals[k], "R2 smram readback");
      acc(20'hA0000, 1'b0, 1'b0, "R7 window normal");
      acc(20'hBFFFF, 1'b1, 1'b0, "R7 window normal end");
      acc(20'hA0000, 1'b1, 1'b1, "R8 window smm");
      acc(20'hBFFFF, 1'b0, 1'b1, "R8 window smm end");
    end
  endtask

  task automatic tTiming();
    cfgWr(8'h5F, 8'h00);
    @(negedge clk);
    #1 chk("R9 idle result invalid", {7'd0, resValid}, 8'd0);
    // write and access in the same cycle: old contents
    cfgWrEn = 1'b1; cfgAddr = 8'h5F; cfgWrData = 8'h11;
    accValid = 1'b1; accAddr = 20'hEC000; accWrite = 1'b0; accSmm = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0;
    chk("R9 result valid", {7'd0, resValid}, 8'd1);
    chk("R9 same cycle old value", {7'd0, resDram}, 8'd0);
    sh[6] = 8'h11;
    @(negedge clk);
    accValid = 1'b0;
    chk("R9 next cycle new value", {7'd0, resDram}, 8'd1);
    @(negedge clk);
    chk("R9 result drops", {7'd0, resValid}, 8'd0);
  endtask

  initial begin
    for (int b = 0; b < 7; b++) sh[b] = 8'h00;
    shSmr = 8'h02;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tLow();
    tRegions(8'h17);
    tRegions(8'h9B);
    tUpperBits();
    tUnmapped();
    tSmram();
    tTiming();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule